// File: doc/BRIEF.md
# Synchronizable Carrier Phase Accumulator with Serial Offset

This block is the phase generator of a digital carrier oscillator. A control processor writes a center frequency word and a phase word into holding registers. Those values stay parked until a transfer moves both of them into the active registers. A transfer is started either by a processor update strobe or by an external sync pulse, and the sync pulse only counts when its enable bit is set. Several devices that share one sync line can therefore switch to new settings on the same clock edge.

A transfer can also clear the accumulator, so that every device sharing the sync starts from a known phase. A separate configuration bit holds the accumulator at zero for as long as it is set. A signed offset frequency can be shifted in serially, most significant bit first, on a data line with a framing line. It has a selectable width, is sign-extended, and is added to the center frequency when enabled. The output is the accumulator plus the active phase word, with a strobe that marks the cycles in which the accumulator advanced.

Top module: `sync_carrier_nco`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, phase_o is 0 and phase_vld_o is 0. Every register clears to zero.
- R2: On each clock edge with step_en high, the accumulator adds the effective frequency modulo 2^32. The effective frequency is the active center frequency, plus the offset when cfg_ofs_en is 1. phase_o is always the accumulator plus the active phase word. phase_vld_o is step_en delayed by one cycle.
- R3: A holding write has no effect on phase_o until a later transfer. hold_wr_freq loads hold_wdata as the frequency, and hold_wr_phase loads it as the phase.
- R4: A cycle with cpu_update high copies both holding registers into the active registers at that clock edge. The new frequency drives accumulation from the next edge on.
- R5: A cycle with ext_sync high transfers exactly like cpu_update when cfg_sync_en is 1. When cfg_sync_en is 0, ext_sync has no effect.
- R6: While cfg_zero_fb is 1, the accumulator is zero after every clock edge, so phase_o equals the active phase word.
- R7: When cfg_load_clear is 1, any transfer (processor or sync) sets the accumulator to zero at the same edge as the register copy. On the next cycle phase_o equals the newly active phase word.
- R8: ofs_sdata is sampled every clock, MSB first. When ofs_sframe is high with the final bit, the last N bits become the offset, sign-extended to 32 bits. N comes from cfg_ofs_width: 00 gives 8, 01 gives 16, 10 gives 24 and 11 gives 32. The new offset takes effect from the next accumulation.
- R9: If ofs_sframe is high before N bits have been sampled since the previous frame or reset, the word is discarded and the offset keeps its value.
- R10: If a holding write and a transfer fall in the same cycle, the transfer moves the previous holding value and the written value waits for the next transfer.
- R11: With step_en low, and neither R6 nor R7 applying, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sync_en | input | 1 | Lets ext_sync start a transfer |
| cfg_zero_fb | input | 1 | Holds the accumulator at zero |
| cfg_load_clear | input | 1 | A transfer also zeroes the accumulator |
| cfg_ofs_en | input | 1 | Adds the serial offset to the center frequency |
| cfg_ofs_width | input | 2 | Offset width code: 8/16/24/32 bits |
| hold_wr_freq | input | 1 | Writes hold_wdata into the frequency holding register |
| hold_wr_phase | input | 1 | Writes hold_wdata into the phase holding register |
| hold_wdata | input | 32 | Holding register write data |
| cpu_update | input | 1 | Processor transfer strobe |
| ext_sync | input | 1 | External sync pulse |
| ofs_sdata | input | 1 | Serial offset data, MSB first |
| ofs_sframe | input | 1 | Marks the final bit of an offset word |
| step_en | input | 1 | Advances the accumulator |
| phase_o | output | 32 | Accumulator plus active phase |
| phase_vld_o | output | 1 | Accumulator advanced in the previous cycle |

## Verification
A holding write can land in the same cycle as a transfer. The bench provokes this by raising hold_wr_freq and cpu_update on one edge. phase_o must first grow by the older frequency and only grow by the newly written one after a second update. A clearing transfer can also coincide with accumulation. There the bench asserts step_en, cfg_load_clear and a transfer strobe together, and expects phase_o to show the new active phase on the next cycle with no step added. Every cycle is compared against a bench model built from the requirements.

// File: rtl/nco_pkg.sv
package nco_pkg;

    localparam int NCO_W = 32;

    // Offset width code: 00 -> 8, 01 -> 16, 10 -> 24, 11 -> 32 bits
    function automatic int ofs_bits(input logic [1:0] code);
        return 8 * (int'(code) + 1);
    endfunction

endpackage

// File: rtl/nco_offset_rx.sv
module nco_offset_rx #(
    parameter int ACC_W = nco_pkg::NCO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sdata_i,
    input  logic             sframe_i,
    input  logic [1:0]       width_i,
    output logic [ACC_W-1:0] ofs_o
);
    localparam int CNT_W = $clog2(ACC_W + 1);

    typedef struct packed {
        logic [ACC_W-1:0] shreg;
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] ofs;
    } rx_t;

    rx_t              st_d, st_q;
    logic [ACC_W-1:0] shifted;
    logic [ACC_W-1:0] keep_mask;
    logic [ACC_W-1:0] sign_pos;
    logic [ACC_W-1:0] sext;
    logic             word_ok;
    int               nbits;

    always_comb begin
        st_d      = st_q;
        nbits     = nco_pkg::ofs_bits(width_i);
        shifted   = {st_q.shreg[ACC_W-2:0], sdata_i};
        keep_mask = {ACC_W{1'b1}} >> (ACC_W - nbits);
        sign_pos  = {{(ACC_W-1){1'b0}}, 1'b1} << (nbits - 1);
        sext      = (|(shifted & sign_pos)) ? (shifted | ~keep_mask)
                                            : (shifted & keep_mask);
        word_ok   = (int'(st_q.cnt) + 1) >= nbits;
        st_d.shreg = shifted;
        if (sframe_i) begin
            st_d.cnt = '0;
            if (word_ok) begin
                st_d.ofs = sext;
            end
        end else if (int'(st_q.cnt) < ACC_W) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ofs_o = st_q.ofs;

    // R9: a frame before a full word leaves the offset untouched
    a_r9_short_word_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (sframe_i && !word_ok) |=> $stable(st_q.ofs));

    // R8: with no frame the offset never changes
    a_r8_offset_only_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !sframe_i |=> $stable(st_q.ofs));

endmodule

// File: rtl/nco_hold_regs.sv
module nco_hold_regs #(
    parameter int ACC_W = nco_pkg::NCO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_freq_i,
    input  logic             wr_phase_i,
    input  logic [ACC_W-1:0] wdata_i,
    input  logic             update_i,
    input  logic             sync_i,
    input  logic             sync_en_i,
    output logic             load_o,
    output logic [ACC_W-1:0] act_freq_o,
    output logic [ACC_W-1:0] act_phase_o
);
    typedef struct packed {
        logic [ACC_W-1:0] hold_f;
        logic [ACC_W-1:0] hold_p;
        logic [ACC_W-1:0] act_f;
        logic [ACC_W-1:0] act_p;
    } regs_t;

    regs_t st_d, st_q;
    logic  load;

    always_comb begin
        st_d = st_q;
        load = update_i || (sync_i && sync_en_i);
        // Transfer reads the old holding value; writes land afterwards (R10)
        if (load) begin
            st_d.act_f = st_q.hold_f;
            st_d.act_p = st_q.hold_p;
        end
        if (wr_freq_i) begin
            st_d.hold_f = wdata_i;
        end
        if (wr_phase_i) begin
            st_d.hold_p = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o      = load;
    assign act_freq_o  = st_q.act_f;
    assign act_phase_o = st_q.act_p;

    // R5: a masked sync with no processor update changes nothing active
    a_r5_sync_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !sync_en_i && !update_i) |=> ($stable(st_q.act_f) && $stable(st_q.act_p)));

    // R4: a processor update copies the holding frequency
    a_r4_update_copies: assert property (@(posedge clk) disable iff (!rst_n)
        update_i |=> (st_q.act_f == $past(st_q.hold_f)));

    // R3: with no transfer the active values stay put
    a_r3_no_transfer_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!update_i && !sync_i) |=> ($stable(st_q.act_f) && $stable(st_q.act_p)));

endmodule

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
    parameter int ACC_W = nco_pkg::NCO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en_i,
    input  logic             load_i,
    input  logic             zero_fb_i,
    input  logic             load_clear_i,
    input  logic             ofs_en_i,
    input  logic [ACC_W-1:0] freq_i,
    input  logic [ACC_W-1:0] ofs_i,
    input  logic [ACC_W-1:0] phase_word_i,
    output logic [ACC_W-1:0] phase_o,
    output logic             phase_vld_o
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             vld;
    } acc_t;

    acc_t             st_d, st_q;
    logic [ACC_W-1:0] eff_freq;
    logic             clear_now;

    always_comb begin
        st_d      = st_q;
        eff_freq  = freq_i + (ofs_en_i ? ofs_i : '0);
        clear_now = zero_fb_i || (load_i && load_clear_i);
        if (clear_now) begin
            st_d.acc = '0;
        end else if (step_en_i) begin
            st_d.acc = st_q.acc + eff_freq;
        end
        st_d.vld = step_en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o     = st_q.acc + phase_word_i;
    assign phase_vld_o = st_q.vld;

    // R6: feedback held at zero
    a_r6_zero_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        zero_fb_i |=> (st_q.acc == '0));

    // R7: a clearing transfer zeroes the accumulator at the load edge
    a_r7_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_clear_i) |=> (st_q.acc == '0));

    // R11: idle accumulator keeps its value
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en_i && !zero_fb_i && !(load_i && load_clear_i)) |=> $stable(st_q.acc));

    // R2: valid strobe follows the step enable by one cycle
    a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
        step_en_i |=> phase_vld_o);

    a_r2_vld_low: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en_i |=> !phase_vld_o);

endmodule

// File: rtl/sync_carrier_nco.sv
module sync_carrier_nco #(
    parameter int ACC_W = nco_pkg::NCO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_sync_en,
    input  logic             cfg_zero_fb,
    input  logic             cfg_load_clear,
    input  logic             cfg_ofs_en,
    input  logic [1:0]       cfg_ofs_width,
    input  logic             hold_wr_freq,
    input  logic             hold_wr_phase,
    input  logic [ACC_W-1:0] hold_wdata,
    input  logic             cpu_update,
    input  logic             ext_sync,
    input  logic             ofs_sdata,
    input  logic             ofs_sframe,
    input  logic             step_en,
    output logic [ACC_W-1:0] phase_o,
    output logic             phase_vld_o
);
    logic             load;
    logic [ACC_W-1:0] act_freq;
    logic [ACC_W-1:0] act_phase;
    logic [ACC_W-1:0] ofs_word;

    nco_hold_regs #(.ACC_W(ACC_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_freq_i   (hold_wr_freq),
        .wr_phase_i  (hold_wr_phase),
        .wdata_i     (hold_wdata),
        .update_i    (cpu_update),
        .sync_i      (ext_sync),
        .sync_en_i   (cfg_sync_en),
        .load_o      (load),
        .act_freq_o  (act_freq),
        .act_phase_o (act_phase)
    );

    nco_offset_rx #(.ACC_W(ACC_W)) u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdata_i  (ofs_sdata),
        .sframe_i (ofs_sframe),
        .width_i  (cfg_ofs_width),
        .ofs_o    (ofs_word)
    );

    nco_phase_accum #(.ACC_W(ACC_W)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_en_i    (step_en),
        .load_i       (load),
        .zero_fb_i    (cfg_zero_fb),
        .load_clear_i (cfg_load_clear),
        .ofs_en_i     (cfg_ofs_en),
        .freq_i       (act_freq),
        .ofs_i        (ofs_word),
        .phase_word_i (act_phase),
        .phase_o      (phase_o),
        .phase_vld_o  (phase_vld_o)
    );

endmodule

// File: tb/sync_carrier_nco_tb_top.sv
module sync_carrier_nco_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_sync_en, cfg_zero_fb, cfg_load_clear, cfg_ofs_en;
    logic [1:0]  cfg_ofs_width;
    logic        hold_wr_freq, hold_wr_phase;
    logic [31:0] hold_wdata;
    logic        cpu_update, ext_sync, ofs_sdata, ofs_sframe, step_en;
    logic [31:0] phase_o;
    logic        phase_vld_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_carrier_nco dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_sync_en(cfg_sync_en), .cfg_zero_fb(cfg_zero_fb),
        .cfg_load_clear(cfg_load_clear), .cfg_ofs_en(cfg_ofs_en),
        .cfg_ofs_width(cfg_ofs_width),
        .hold_wr_freq(hold_wr_freq), .hold_wr_phase(hold_wr_phase),
        .hold_wdata(hold_wdata), .cpu_update(cpu_update), .ext_sync(ext_sync),
        .ofs_sdata(ofs_sdata), .ofs_sframe(ofs_sframe), .step_en(step_en),
        .phase_o(phase_o), .phase_vld_o(phase_vld_o)
    );

    typedef struct {
        logic [31:0] ph;
        logic        vld;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   n_checks = 0;
    int   n_fail   = 0;

    // staged stimulus
    logic        s_sync_en = 0, s_zero = 0, s_ld_clr = 0, s_ofs_en = 0, s_adv = 0;
    logic [1:0]  s_wcode = 0;
    logic        s_wr_f = 0, s_wr_p = 0, s_upd = 0, s_sync = 0, s_ser = 0, s_frame = 0;
    logic [31:0] s_wdata = 0;

    // requirement model
    logic [31:0] m_acc = 0, m_hf = 0, m_hp = 0, m_af = 0, m_ap = 0, m_sh = 0, m_ofs = 0;
    int          m_cnt = 0;

    task automatic step(input string tag);
        logic        ld;
        logic [31:0] stepv;
        logic [31:0] tmp;
        int          nb;
        exp_t        it;
        @(negedge clk); #1;
        cfg_sync_en = s_sync_en; cfg_zero_fb = s_zero; cfg_load_clear = s_ld_clr;
        cfg_ofs_en = s_ofs_en; cfg_ofs_width = s_wcode; step_en = s_adv;
        hold_wr_freq = s_wr_f; hold_wr_phase = s_wr_p; hold_wdata = s_wdata;
        cpu_update = s_upd; ext_sync = s_sync; ofs_sdata = s_ser; ofs_sframe = s_frame;
        ld    = s_upd | (s_sync & s_sync_en);
        stepv = m_af + (s_ofs_en ? m_ofs : 32'd0);
        if (s_zero || (ld && s_ld_clr)) m_acc = 0;
        else if (s_adv) m_acc = m_acc + stepv;
        if (ld) begin m_af = m_hf; m_ap = m_hp; end
        if (s_wr_f) m_hf = s_wdata;
        if (s_wr_p) m_hp = s_wdata;
        nb   = 8 * (int'(s_wcode) + 1);
        m_sh = {m_sh[30:0], s_ser};
        if (s_frame) begin
            if (m_cnt + 1 >= nb) begin
                tmp   = m_sh << (32 - nb);
                m_ofs = $signed(tmp) >>> (32 - nb);
            end
            m_cnt = 0;
        end else if (m_cnt < 32) begin
            m_cnt++;
        end
        it.ph = m_acc + m_ap; it.vld = s_adv; it.tag = tag;
        q.push_back(it);
        s_wr_f = 0; s_wr_p = 0; s_upd = 0; s_sync = 0; s_frame = 0; s_ser = 0;
    endtask

    task automatic send_word(input logic [31:0] val, input int nb, input string tag);
        for (int i = nb - 1; i >= 0; i--) begin
            s_ser   = val[i];
            s_frame = (i == 0);
            step(tag);
        end
    endtask

    // monitor: compares outputs against the expected queue
    always @(negedge clk) begin
        if (q.size() > 0) begin
            e = q.pop_front();
            n_checks++;
            if (phase_o !== e.ph || phase_vld_o !== e.vld) begin
                n_fail++;
                $display("FAIL %s phase=%h vld=%b expected phase=%h vld=%b",
                         e.tag, phase_o, phase_vld_o, e.ph, e.vld);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0;
        cfg_sync_en = 0; cfg_zero_fb = 0; cfg_load_clear = 0; cfg_ofs_en = 0;
        cfg_ofs_width = 0; hold_wr_freq = 0; hold_wr_phase = 0; hold_wdata = 0;
        cpu_update = 0; ext_sync = 0; ofs_sdata = 0; ofs_sframe = 0; step_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (phase_o !== 32'd0 || phase_vld_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 phase=%h vld=%b expected phase=0 vld=0", phase_o, phase_vld_o);
        end
        rst_n = 1;
        step("R1");

        // R3: holding write alone does nothing
        s_adv = 1;
        s_wdata = 32'h100; s_wr_f = 1; step("R3");
        repeat (3) step("R3");
        // R4: processor update
        s_upd = 1; step("R4");
        repeat (4) step("R2");
        s_wdata = 32'h1000_0000; s_wr_f = 1; step("R3");
        s_wdata = 32'h40; s_wr_p = 1; step("R3");
        step("R3");
        // R5: masked then enabled sync
        s_sync = 1; step("R5");
        repeat (2) step("R5");
        s_sync_en = 1; s_sync = 1; step("R5");
        repeat (3) step("R5");
        // R11: idle
        s_adv = 0; repeat (3) step("R11");
        s_adv = 1;
        // R7: clearing processor transfer, then wrap (R2)
        s_wdata = 32'hFFFF_FFF0; s_wr_f = 1; step("R2");
        s_ld_clr = 1; s_upd = 1; step("R7");
        step("R7");
        s_ld_clr = 0; repeat (4) step("R2");
        // R6: zero feedback
        s_zero = 1; repeat (3) step("R6");
        s_zero = 0; step("R6");
        step("R6");
        // R10: write and transfer on the same edge
        s_wdata = 32'h30; s_wr_f = 1; step("R10");
        s_wdata = 32'h50; s_wr_f = 1; s_upd = 1; step("R10");
        repeat (2) step("R10");
        s_upd = 1; step("R10");
        repeat (2) step("R10");
        // R7: clearing sync transfer
        s_wdata = 32'h77; s_wr_p = 1; step("R7");
        s_ld_clr = 1; s_sync = 1; step("R7");
        step("R7");
        s_ld_clr = 0; step("R7");
        // R8: offset at each width
        s_wdata = 32'h10; s_wr_f = 1; step("R8");
        s_upd = 1; step("R8");
        s_ofs_en = 1;
        s_wcode = 2'b00; send_word(32'h85, 8, "R8");        repeat (3) step("R8");
        s_wcode = 2'b01; send_word(32'h1234, 16, "R8");     repeat (3) step("R8");
        s_wcode = 2'b10; send_word(32'h80_0001, 24, "R8");  repeat (3) step("R8");
        s_wcode = 2'b11; send_word(32'h8000_0003, 32, "R8"); repeat (3) step("R8");
        // R9: short word discarded, then a full word accepted
        s_wcode = 2'b00; send_word(32'h12, 8, "R9");
        send_word(32'h7, 5, "R9");  repeat (3) step("R9");
        send_word(32'h7F, 8, "R9"); repeat (3) step("R9");
        s_ofs_en = 0; repeat (2) step("R8");

        @(negedge clk); @(negedge clk); #1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule